// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between a clock generator's internal sources and its output pins and decides, group by group, whether each clock reaches its pin or is held low. It gates a free-running processor clock, a stoppable processor clock, a bank of PCI clocks, a bank of memory clocks copied from one memory source clock, an interrupt-controller clock, and a super-I/O clock that runs either at the 48 MHz source rate or at half of it.

Two active-low control pins drive the gating. A processor-stop pin halts only the stoppable processor clock, and it counts only when a strap, captured once after reset, has given that pin its control role. A power-down pin halts the stoppable processor clock, the PCI bank, the memory bank and the interrupt-controller clock. Each source is modelled as a level sampled by a fast control clock. Every request passes through a two-stage synchroniser, and the enable for each group changes only while that group's source is low. The result is that gated outputs are held low, never float, and never show a shortened high phase. One configuration bit chooses the super-I/O rate. Its reset value selects the full 48 MHz rate.

Top module: `clk_out_gate`

## Requirements
- R1: While `rst_n` is low, every clock output is 0.
- R2: `cpu_free_out` repeats `cpu_src` one control-clock cycle later, whatever the levels of `stop_n` and `pwrdn_n`.
- R3: When the stop pin role is active and `stop_n` stays low, `cpu_stop_out` is held at 0 from the first low phase of `cpu_src` that follows two synchroniser cycles.
- R4: When `strap_mode` was 1 at the first clock after reset, `stop_n` has no effect on `cpu_stop_out`.
- R5: While `pwrdn_n` stays low, `cpu_stop_out`, `pci_out`, `sdram_out` and `apic_out` are held at 0, and `cpu_free_out` and `sio_out` keep running.
- R6: All bits of `pci_out` are equal at all times, and so are all bits of `sdram_out`. `sdram_out` copies `sdram_src` one cycle later when it is enabled.
- R7: A gated output never shows a high phase shorter than its source's high phase.
- R8: After a request is released, the output resumes with a complete high phase, starting in the first low phase of the source after the request has crossed the synchroniser.
- R9: `sio_out` follows `clk48_src` when the rate bit is 0. When the rate bit is 1, it follows a divide-by-two of `clk48_src`. The rate bit is loaded from `cfg_sio_half` in a cycle where `cfg_wr` is 1, and it resets to 0. A new rate takes effect only while both candidate clocks are low.
- R10: A change on `stop_n` or `pwrdn_n` reaches the enable after exactly two control-clock stages.
- R11: `strap_mode` is captured only at the first clock after reset. A value of 0 gives `stop_n` its role. Later changes of `strap_mode` are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock that samples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Active-low processor stop request |
| pwrdn_n | input | 1 | Active-low power-down request |
| strap_mode | input | 1 | Power-on strap; 0 gives stop_n its role |
| cfg_wr | input | 1 | Load strobe for the rate bit |
| cfg_sio_half | input | 1 | Rate bit value; 1 selects half rate |
| cpu_src | input | 1 | Processor clock source level |
| pci_src | input | 1 | PCI clock source level |
| sdram_src | input | 1 | Memory clock input level |
| apic_src | input | 1 | Interrupt-controller clock source level |
| clk48_src | input | 1 | 48 MHz source level |
| cpu_free_out | output | 1 | Free-running processor clock |
| cpu_stop_out | output | 1 | Stoppable processor clock |
| pci_out | output | NUM_PCI | PCI clock bank |
| sdram_out | output | NUM_SDRAM | Memory clock bank |
| apic_out | output | 1 | Interrupt-controller clock |
| sio_out | output | 1 | Super-I/O clock |

## Verification
The sources run at different periods (4, 8, 6, 10 and 2 control cycles), so the same request arrives at a different point in each group's phase. Stop requests are held for several lengths and start at several offsets, which separates correct gating in the low phase from a slip by one cycle. The power-down windows show which groups stop and which keep running. The strap is tested in both states and is also changed after it has been captured, which shows whether stop_n is honoured, ignored, or re-read. The super-I/O rate is measured by counting edges before and after the rate bit is written.

// File: rtl/clk_out_gate_pkg.sv
package clk_out_gate_pkg;
  localparam int GRP_CPU_FREE = 0;
  localparam int GRP_CPU_STOP = 1;
  localparam int GRP_PCI      = 2;
  localparam int GRP_SDRAM    = 3;
  localparam int GRP_APIC     = 4;
  localparam int GRP_SIO      = 5;
  localparam int NUM_GROUPS   = 6;
endpackage

// File: rtl/cog_sync.sv
module cog_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cog_gate_cell.sv
module cog_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic req_async,
  output logic gated_o
);
  logic req_s;
  logic en_q, en_d;
  logic out_q, out_d;

  cog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_async),
    .q     (req_s)
  );

  always_comb begin
    en_d  = src ? en_q : ~req_s;
    out_d = src & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign gated_o = out_q;
endmodule

// File: rtl/cog_sio_src.sv
module cog_sio_src (
  input  logic clk,
  input  logic rst_n,
  input  logic clk48,
  input  logic cfg_wr,
  input  logic cfg_half,
  output logic sio_src_o
);
  logic half_q, half_d;
  logic c48_q;
  logic div_q, div_d;
  logic sel_q, sel_d;
  logic sel_ok;

  always_comb begin
    half_d = cfg_wr ? cfg_half : half_q;
    div_d  = div_q ^ (clk48 & ~c48_q);
    sel_ok = ~clk48 & ~div_q;
    sel_d  = sel_ok ? half_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      c48_q  <= 1'b0;
      div_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      c48_q  <= clk48;
      div_q  <= div_d;
      sel_q  <= sel_d;
    end
  end

  assign sio_src_o = sel_q ? div_q : clk48;
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
  import clk_out_gate_pkg::*;
#(
  parameter int NUM_PCI     = 6,
  parameter int NUM_SDRAM   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stop_n,
  input  logic                 pwrdn_n,
  input  logic                 strap_mode,
  input  logic                 cfg_wr,
  input  logic                 cfg_sio_half,
  input  logic                 cpu_src,
  input  logic                 pci_src,
  input  logic                 sdram_src,
  input  logic                 apic_src,
  input  logic                 clk48_src,
  output logic                 cpu_free_out,
  output logic                 cpu_stop_out,
  output logic [NUM_PCI-1:0]   pci_out,
  output logic [NUM_SDRAM-1:0] sdram_out,
  output logic                 apic_out,
  output logic                 sio_out
);
  logic strap_done_q;
  logic stop_mode_q, stop_mode_d;
  logic sio_src;
  logic [NUM_GROUPS-1:0] grp_src;
  logic [NUM_GROUPS-1:0] grp_req;
  logic [NUM_GROUPS-1:0] grp_out;

  // Strap capture: once, on the first clock after reset.
  always_comb begin
    stop_mode_d = strap_done_q ? stop_mode_q : ~strap_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done_q <= 1'b0;
      stop_mode_q  <= 1'b0;
    end else begin
      strap_done_q <= 1'b1;
      stop_mode_q  <= stop_mode_d;
    end
  end

  cog_sio_src u_sio_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk48     (clk48_src),
    .cfg_wr    (cfg_wr),
    .cfg_half  (cfg_sio_half),
    .sio_src_o (sio_src)
  );

  always_comb begin
    grp_src[GRP_CPU_FREE] = cpu_src;
    grp_src[GRP_CPU_STOP] = cpu_src;
    grp_src[GRP_PCI]      = pci_src;
    grp_src[GRP_SDRAM]    = sdram_src;
    grp_src[GRP_APIC]     = apic_src;
    grp_src[GRP_SIO]      = sio_src;

    grp_req[GRP_CPU_FREE] = 1'b0;
    grp_req[GRP_CPU_STOP] = ~pwrdn_n | (~stop_n & stop_mode_q);
    grp_req[GRP_PCI]      = ~pwrdn_n;
    grp_req[GRP_SDRAM]    = ~pwrdn_n;
    grp_req[GRP_APIC]     = ~pwrdn_n;
    grp_req[GRP_SIO]      = 1'b0;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cell
    cog_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (grp_src[g]),
      .req_async (grp_req[g]),
      .gated_o   (grp_out[g])
    );
  end

  assign cpu_free_out = grp_out[GRP_CPU_FREE];
  assign cpu_stop_out = grp_out[GRP_CPU_STOP];
  assign pci_out      = {NUM_PCI{grp_out[GRP_PCI]}};
  assign sdram_out    = {NUM_SDRAM{grp_out[GRP_SDRAM]}};
  assign apic_out     = grp_out[GRP_APIC];
  assign sio_out      = grp_out[GRP_SIO];
endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk #(
  parameter int NUM_PCI   = 6,
  parameter int NUM_SDRAM = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 stop_n,
  input logic                 pwrdn_n,
  input logic                 stop_mode_q,
  input logic                 cpu_src,
  input logic                 sdram_src,
  input logic                 cpu_free_out,
  input logic                 cpu_stop_out,
  input logic [NUM_PCI-1:0]   pci_out,
  input logic [NUM_SDRAM-1:0] sdram_out
);
  assert_free_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_free_out |-> $past(cpu_src));

  assert_stop_rise_allowed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stop_out) |-> ($past(pwrdn_n, 4) && ($past(stop_n, 4) || !$past(stop_mode_q, 4))));

  assert_pd_rise_allowed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_out[0]) |-> $past(pwrdn_n, 4));

  assert_sdram_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_out[NUM_SDRAM-1] |-> $past(sdram_src));

  assert_no_runt_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stop_out) |-> !$past(cpu_src));

  assert_no_runt_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stop_out) |-> !$past(cpu_src, 2));
endmodule

bind clk_out_gate clk_out_gate_chk #(.NUM_PCI(NUM_PCI), .NUM_SDRAM(NUM_SDRAM)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_n       (stop_n),
  .pwrdn_n      (pwrdn_n),
  .stop_mode_q  (stop_mode_q),
  .cpu_src      (cpu_src),
  .sdram_src    (sdram_src),
  .cpu_free_out (cpu_free_out),
  .cpu_stop_out (cpu_stop_out),
  .pci_out      (pci_out),
  .sdram_out    (sdram_out)
);

// File: tb/clk_out_gate_test.sv
module clk_out_gate_test;
  logic clk = 1'b0;
  logic rst_n, stop_n, pwrdn_n, strap_mode, cfg_wr, cfg_sio_half;
  logic cpu_src, pci_src, sdram_src, apic_src, clk48_src;
  logic cpu_free_out, cpu_stop_out, apic_out, sio_out;
  logic [5:0]  pci_out;
  logic [12:0] sdram_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;

  // reference model state, index: 0 free cpu, 1 stop cpu, 2 pci, 3 sdram, 4 apic, 5 sio
  bit [5:0] m_s1, m_s2, m_en, m_out, m_src, m_req;
  bit m_done, m_mode, m_half, m_c48, m_div, m_sel, m_sio_src;

  // observation state
  bit p_cs, p_cf, p_pci, p_sio, p_sd, p_ap;
  int r_cs, r_cf, r_pci, r_sio, r_sd, r_ap;
  int run_cs, run_pci;

  always #4 clk = ~clk;

  clk_out_gate uut (
    .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .pwrdn_n(pwrdn_n),
    .strap_mode(strap_mode), .cfg_wr(cfg_wr), .cfg_sio_half(cfg_sio_half),
    .cpu_src(cpu_src), .pci_src(pci_src), .sdram_src(sdram_src),
    .apic_src(apic_src), .clk48_src(clk48_src),
    .cpu_free_out(cpu_free_out), .cpu_stop_out(cpu_stop_out),
    .pci_out(pci_out), .sdram_out(sdram_out), .apic_out(apic_out),
    .sio_out(sio_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // source patterns, driven away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    cpu_src   <= ((cyc + 1) % 4) < 2;
    pci_src   <= ((cyc + 1) % 8) < 4;
    sdram_src <= ((cyc + 1) % 6) < 3;
    apic_src  <= ((cyc + 1) % 10) < 5;
    clk48_src <= ((cyc + 1) % 2) == 0;
  end

  // cycle model and per-cycle comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_en = '0; m_out = '0;
      m_done = 0; m_mode = 0; m_half = 0; m_c48 = 0; m_div = 0; m_sel = 0;
    end else begin
      m_sio_src = m_sel ? m_div : clk48_src;
      m_src = {m_sio_src, apic_src, sdram_src, pci_src, cpu_src, cpu_src};
      m_req[0] = 0;
      m_req[1] = !pwrdn_n || (!stop_n && m_mode);
      m_req[2] = !pwrdn_n;
      m_req[3] = !pwrdn_n;
      m_req[4] = !pwrdn_n;
      m_req[5] = 0;
      for (int g = 0; g < 6; g++) begin
        m_out[g] = m_src[g] & m_en[g];
        if (!m_src[g]) m_en[g] = !m_s2[g];
        m_s2[g] = m_s1[g];
        m_s1[g] = m_req[g];
      end
      if (!clk48_src && !m_div) m_sel = m_half;
      m_div = m_div ^ (clk48_src & !m_c48);
      m_c48 = clk48_src;
      if (cfg_wr) m_half = cfg_sio_half;
      if (!m_done) begin m_mode = !strap_mode; m_done = 1; end
    end
    #1;
    chk("R2 cpu_free_out", cpu_free_out, m_out[0]);
    chk("R3/R10 cpu_stop_out", cpu_stop_out, m_out[1]);
    chk("R6 pci_out copies", pci_out, {6{m_out[2]}});
    chk("R6 sdram_out copies", sdram_out, {13{m_out[3]}});
    chk("R5 apic_out", apic_out, m_out[4]);
    chk("R9 sio_out", sio_out, m_out[5]);
    if (!rst_n) begin
      run_cs = 0; run_pci = 0;
    end else begin
      if (cpu_stop_out) run_cs++;
      else if (run_cs > 0) begin chk("R7/R8 cpu_stop high width", run_cs, 2); run_cs = 0; end
      if (pci_out[0]) run_pci++;
      else if (run_pci > 0) begin chk("R7 pci high width", run_pci, 4); run_pci = 0; end
    end
    if (cpu_stop_out && !p_cs) r_cs++;
    if (cpu_free_out && !p_cf) r_cf++;
    if (pci_out[0] && !p_pci) r_pci++;
    if (sio_out && !p_sio) r_sio++;
    if (sdram_out[0] && !p_sd) r_sd++;
    if (apic_out && !p_ap) r_ap++;
    p_cs = cpu_stop_out; p_cf = cpu_free_out; p_pci = pci_out[0];
    p_sio = sio_out; p_sd = sdram_out[0]; p_ap = apic_out;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    r_cs = 0; r_cf = 0; r_pci = 0; r_sio = 0; r_sd = 0; r_ap = 0;
  endtask

  task automatic check_reset_state();
    chk("R1 outputs in reset", {cpu_free_out, cpu_stop_out, apic_out, sio_out, pci_out, sdram_out}, 0);
  endtask

  initial begin
    rst_n = 0; stop_n = 1; pwrdn_n = 1; strap_mode = 0; cfg_wr = 0; cfg_sio_half = 0;
    cpu_src = 0; pci_src = 0; sdram_src = 0; apic_src = 0; clk48_src = 0;
    run(5);
    check_reset_state();
    rst_n = 1;
    run(40);

    clear_counts(); run(32);
    chk("R9 default full rate sio rises", r_sio, 16);
    chk("R2 free cpu rises", r_cf, 8);
    chk("R3 stoppable cpu running", r_cs, 8);

    stop_n = 0; run(8);
    clear_counts(); run(24);
    chk("R3 cpu_stop_out held low", r_cs, 0);
    chk("R2 free cpu unaffected by stop", r_cf, 6);
    chk("R3 pci unaffected by stop", r_pci, 3);
    stop_n = 1; run(8);
    clear_counts(); run(24);
    chk("R8 cpu_stop_out resumed", r_cs, 6);

    for (int k = 0; k < 4; k++) begin
      stop_n = 0; run(5 + k);
      stop_n = 1; run(12 + k);
    end

    pwrdn_n = 0; run(10);
    clear_counts(); run(24);
    chk("R5 cpu_stop_out off", r_cs, 0);
    chk("R5 pci off", r_pci, 0);
    chk("R5 sdram off", r_sd, 0);
    chk("R5 apic off", r_ap, 0);
    chk("R5 free cpu runs", r_cf, 6);
    chk("R5 sio runs", r_sio, 12);
    pwrdn_n = 1; run(20);
    clear_counts(); run(60);
    chk("R5 apic resumed", r_ap, 6);
    chk("R6 sdram resumed", r_sd, 10);

    cfg_sio_half = 1; cfg_wr = 1; run(1);
    cfg_wr = 0; cfg_sio_half = 0; run(16);
    clear_counts(); run(32);
    chk("R9 half rate sio rises", r_sio, 8);

    strap_mode = 1; stop_n = 0; run(8);
    clear_counts(); run(24);
    chk("R11 late strap change ignored", r_cs, 0);
    stop_n = 1; run(12);

    rst_n = 0; run(3);
    check_reset_state();
    rst_n = 1; run(12);
    strap_mode = 0;
    stop_n = 0; run(8);
    clear_counts(); run(24);
    chk("R4 stop ignored with strap high", r_cs, 6);
    chk("R9 rate bit reset to full rate", r_sio, 12);
    stop_n = 1; run(8);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule